// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a serial management master for an external Ethernet PHY. A host sets the PHY address and the register address, chooses a clock-range code, and then starts one transaction. A write starts when the host writes the write-data register. A read starts when the host sets the read-command bit. The block then builds the whole management frame by itself and shifts it out on MDIO. It produces MDC from the system clock, and MDC runs only while that frame is in progress.

A busy flag tells the host when the result can be used. For a write, busy low means the data has been sent. For a read, busy low means the 16 bits sampled from the PHY sit in the read-data register. The block drives MDIO on falling MDC edges. It releases the line during the turnaround and the data of a read, and samples on rising MDC edges.

Host writes use a strobe, a 2-bit register select and a 16-bit data word:
- Select 0 holds the addresses: PHY address in bits [9:5], register address in bits [4:0].
- Select 1 is write data.
- Select 2 is the command word: bit 0 requests a read.
- Select 3 is the clock-range code in bits [1:0].

Top module: `mdio_frame_ctrl`

## Requirements
- R1: After reset, busy, rd_cmd, mdc and mdio_oe are all 0.
- R2: The clock-range code gives an MDC period of 14, 20 or 28 system clocks for codes 01, 10 and 11. A whole frame keeps busy high for exactly 64 periods. The code is captured when a transaction starts.
- R3: While the clock-range code is 00, no write or read request starts a transaction, and busy stays 0.
- R4: mdc stays low whenever busy is low. Each frame has exactly 64 rising MDC edges.
- R5: The frame bits, indexed 0 to 63 in time order, are as follows. Bits 0–31 are 32 ones. Bits 32–33 are start bits 0 then 1. Bits 34–35 are the opcode. Bits 36–40 are the PHY address, MSB first. Bits 41–45 are the register address, MSB first. Bits 46–47 are the turnaround. Bits 48–63 are data, MSB first.
- R6: A write to select 1 starts a write frame. Its opcode is 0,1, its turnaround is 1,0, and its data field is the written word. mdio_oe stays 1 for all 64 bits.
- R7: Writing 1 to bit 0 of select 2 starts a read frame with opcode 1,0. mdio_oe is 1 for bits 0–45 and 0 for bits 46–63.
- R8: In a read, the block samples MDIO at the rising MDC edges of bits 48–63 and takes the first sample as the MSB. The 16-bit word appears on rd_data when busy falls.
- R9: mdio_o changes only at falling MDC edges, so it is stable for every high phase of MDC.
- R10: A write or read request made while busy is high is ignored. No second frame follows, and rd_data keeps its value.
- R11: rd_cmd reads 1 while a read runs and clears itself at the same edge at which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 addresses, 1 write data, 2 command, 3 clock range |
| host_wdata | input | 16 | Host write data |
| busy | output | 1 | Transaction in progress |
| rd_cmd | output | 1 | Read-command bit, cleared by hardware at read end |
| rd_data | output | 16 | Last word read from the PHY |
| mdc | output | 1 | Management clock, low when idle |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
A wrong bit counter shows up quickly. The number of rising MDC edges per frame would differ from 64, or a field would land at the wrong position in the captured bit stream. A wrong divide count changes the busy length, which the bench sees by the end of the first frame. A release of MDIO at the wrong time shows in mdio_oe at the rising MDC edge of the affected bit. A read shift error shows on rd_data at the edge where busy falls. A busy or start guard that lets a request in during a frame produces extra MDC edges within one MDC period of that request.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_WDATA = 2'd1,
    SEL_CMD   = 2'd2,
    SEL_CLK   = 2'd3
  } host_sel_e;

  // Half an MDC period in system clocks for a clock-range code.
  function automatic int unsigned mdc_half(input logic [1:0] code,
                                           input int unsigned div_lo,
                                           input int unsigned div_mid,
                                           input int unsigned div_hi);
    case (code)
      2'b01:   return div_lo / 2;
      2'b10:   return div_mid / 2;
      2'b11:   return div_hi / 2;
      default: return div_lo / 2;
    endcase
  endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen
  import mdio_pkg::*;
#(
  parameter int DIV_LO  = 14,
  parameter int DIV_MID = 20,
  parameter int DIV_HI  = 28
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] code,
  output logic       mdc,
  output logic       tick_rise,
  output logic       tick_fall
);
  localparam int CNT_W = $clog2(DIV_HI);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             at_end;

  always_comb begin
    half_m1 = CNT_W'(mdc_half(code, DIV_LO, DIV_MID, DIV_HI) - 1);
  end

  assign at_end    = en && (cnt == half_m1);
  assign tick_rise = at_end && !mdc;
  assign tick_fall = at_end && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (at_end) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4: once the enable drops, MDC is low on the next cycle
  assert_mdc_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);

  // R2: the half-period counter never runs past its terminal value
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt <= half_m1));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_rd,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick_rise,
  input  logic              tick_fall,
  input  logic              mdio_i,
  output logic              active,
  output logic              done,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic [DATA_W-1:0] rdata
);
  localparam int FRAME_W  = PRE_LEN + 6 + 2 * ADDR_W + DATA_W;
  localparam int TA_IDX   = PRE_LEN + 4 + 2 * ADDR_W;
  localparam int DATA_IDX = TA_IDX + 2;
  localparam int IDX_W    = $clog2(FRAME_W);

  function automatic logic [FRAME_W-1:0] build_frame(input logic rd,
                                                     input logic [ADDR_W-1:0] pa,
                                                     input logic [ADDR_W-1:0] ra,
                                                     input logic [DATA_W-1:0] d);
    return {{PRE_LEN{1'b1}}, 2'b01, (rd ? 2'b10 : 2'b01), pa, ra,
            (rd ? 2'b11 : 2'b10), (rd ? {DATA_W{1'b1}} : d)};
  endfunction

  logic [FRAME_W-1:0] shreg;
  logic [IDX_W-1:0]   idx;
  logic               is_rd;
  logic [DATA_W-1:0]  rsh;
  logic               last_bit;
  logic               in_data;
  logic               released;

  assign last_bit = (idx == IDX_W'(FRAME_W - 1));
  assign in_data  = (idx >= IDX_W'(DATA_IDX));
  assign released = is_rd && (idx >= IDX_W'(TA_IDX));
  assign done     = active && tick_fall && last_bit;
  assign mdio_o   = active ? shreg[FRAME_W-1] : 1'b1;
  assign mdio_oe  = active && !released;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      is_rd  <= 1'b0;
      shreg  <= '1;
      rsh    <= '0;
      rdata  <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      idx    <= '0;
      is_rd  <= start_rd;
      shreg  <= build_frame(start_rd, phy_addr, reg_addr, wdata);
    end else if (active) begin
      if (tick_rise && is_rd && in_data) rsh <= {rsh[DATA_W-2:0], mdio_i};
      if (tick_fall) begin
        if (last_bit) begin
          active <= 1'b0;
          if (is_rd) rdata <= rsh;
        end else begin
          idx   <= idx + 1'b1;
          shreg <= shreg << 1;
        end
      end
    end
  end

  // R9: the driven MDIO bit moves only on a falling MDC tick
  assert_mdio_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick_fall) |=> $stable(mdio_o));

  // R7: during a read, the line stays released once the turnaround is reached
  assert_release_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mdio_oe && !done) |=> !mdio_oe);

  // R8: read data register only changes at the end of a frame
  assert_rdata_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rdata));

endmodule

// File: rtl/mdio_frame_ctrl.sv
module mdio_frame_ctrl
  import mdio_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int PRE_LEN = 32,
  parameter int DIV_LO  = 14,
  parameter int DIV_MID = 20,
  parameter int DIV_HI  = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [1:0]        host_sel,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              busy,
  output logic              rd_cmd,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] regad_q;
  logic [1:0]        code_q;
  logic [1:0]        run_code;
  logic              rd_cmd_q;
  logic              can_start;
  logic              start_wr;
  logic              start_rd;
  logic              seq_active;
  logic              seq_done;
  logic              tick_rise;
  logic              tick_fall;

  assign can_start = (code_q != 2'b00) && !seq_active;
  assign start_wr  = host_we && (host_sel == SEL_WDATA) && can_start;
  assign start_rd  = host_we && (host_sel == SEL_CMD) && host_wdata[0] && can_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_q    <= '0;
      regad_q  <= '0;
      code_q   <= 2'b00;
      run_code <= 2'b01;
      rd_cmd_q <= 1'b0;
    end else begin
      if (host_we && host_sel == SEL_ADDR) begin
        phy_q   <= host_wdata[2*ADDR_W-1:ADDR_W];
        regad_q <= host_wdata[ADDR_W-1:0];
      end
      if (host_we && host_sel == SEL_CLK) code_q <= host_wdata[1:0];
      if (start_wr || start_rd) run_code <= code_q;
      if (start_rd) rd_cmd_q <= 1'b1;
      else if (seq_done) rd_cmd_q <= 1'b0;
    end
  end

  mdio_clk_gen #(
    .DIV_LO (DIV_LO),
    .DIV_MID(DIV_MID),
    .DIV_HI (DIV_HI)
  ) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (seq_active),
    .code     (run_code),
    .mdc      (mdc),
    .tick_rise(tick_rise),
    .tick_fall(tick_fall)
  );

  mdio_frame_seq #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .PRE_LEN(PRE_LEN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_wr || start_rd),
    .start_rd (start_rd),
    .phy_addr (phy_q),
    .reg_addr (regad_q),
    .wdata    (host_wdata),
    .tick_rise(tick_rise),
    .tick_fall(tick_fall),
    .mdio_i   (mdio_i),
    .active   (seq_active),
    .done     (seq_done),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .rdata    (rd_data)
  );

  assign busy   = seq_active;
  assign rd_cmd = rd_cmd_q;

  // R3: with code 00 an idle controller stays idle
  assert_no_start_code0_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_q == 2'b00 && !busy) |=> !busy);

  // R10: busy only drops through the end-of-frame event
  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !seq_done) |=> busy);

  // R11: the read-command bit is clear once busy has fallen
  assert_rdcmd_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !rd_cmd);

  // R4: MDC never high while idle
  assert_mdc_low_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

endmodule

// File: tb/sim_mdio_frame_ctrl.sv
`timescale 1ns/1ps
module sim_mdio_frame_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [1:0]  host_sel = 2'd0;
  logic [15:0] host_wdata = 16'h0;
  logic        busy, rd_cmd, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  int checks = 0;
  int fails = 0;
  int rcnt = 0;
  int busy_cyc = 0;
  int stab_err = 0;
  logic        held = 1'b1;
  logic [63:0] got_bits;
  logic [63:0] got_oe;
  logic [15:0] rd_pat = 16'h0;

  always #2.5 clk = ~clk;

  mdio_frame_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .busy(busy), .rd_cmd(rd_cmd), .rd_data(rd_data),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  // PHY-side capture on rising MDC
  always @(posedge mdc) begin
    #1;
    if (rcnt < 64) begin
      got_bits[63-rcnt] = mdio_o;
      got_oe[63-rcnt]   = mdio_oe;
    end
    held = mdio_o;
    rcnt = rcnt + 1;
  end

  // PHY drives read data after the falling MDC edge
  always @(negedge mdc) begin
    #1;
    if (rcnt >= 48 && rcnt < 64) mdio_i = rd_pat[63-rcnt];
    else mdio_i = 1'b1;
  end

  always @(negedge clk) begin
    if (busy) busy_cyc = busy_cyc + 1;
    if (mdc && (mdio_o !== held)) stab_err = stab_err + 1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic clear_mon();
    rcnt = 0; busy_cyc = 0; stab_err = 0; got_bits = '0; got_oe = '0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (40) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_frame(input logic rd, input logic [4:0] pa,
                                            input logic [4:0] ra, input logic [15:0] d);
    logic [63:0] f;
    f[63:32] = 32'hFFFF_FFFF;
    f[31:30] = 2'b01;
    f[29:28] = rd ? 2'b10 : 2'b01;
    f[27:23] = pa;
    f[22:18] = ra;
    f[17:16] = 2'b10;
    f[15:0]  = d;
    return f;
  endfunction

  task automatic t_reset();
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 rd_cmd", 64'(rd_cmd), 64'd0);
    chk("R1 mdc", 64'(mdc), 64'd0);
    chk("R1 mdio_oe", 64'(mdio_oe), 64'd0);
  endtask

  task automatic t_code_zero();
    clear_mon();
    host_write(2'd1, 16'h1234);
    host_write(2'd2, 16'h0001);
    repeat (60) @(negedge clk);
    chk("R3 busy stays low", 64'(busy_cyc), 64'd0);
    chk("R3 no mdc edges", 64'(rcnt), 64'd0);
    chk("R3 rd_cmd not set", 64'(rd_cmd), 64'd0);
  endtask

  task automatic t_write(input logic [1:0] code, input int n, input logic [4:0] pa,
                         input logic [4:0] ra, input logic [15:0] d);
    host_write(2'd3, {14'h0, code});
    host_write(2'd0, {6'h0, pa, ra});
    clear_mon();
    host_write(2'd1, d);
    chk("R10 busy set at start", 64'(busy), 64'd1);
    wait_idle();
    chk("R5 R6 write frame bits", got_bits, exp_frame(1'b0, pa, ra, d));
    chk("R6 oe high all bits", got_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R4 64 mdc rises", 64'(rcnt), 64'd64);
    chk("R2 busy length", 64'(busy_cyc), 64'(64 * n));
    chk("R9 mdio stable while mdc high", 64'(stab_err), 64'd0);
    chk("R4 mdc low after frame", 64'(mdc), 64'd0);
  endtask

  task automatic t_read(input logic [1:0] code, input int n, input logic [4:0] pa,
                        input logic [4:0] ra, input logic [15:0] pat);
    host_write(2'd3, {14'h0, code});
    host_write(2'd0, {6'h0, pa, ra});
    rd_pat = pat;
    clear_mon();
    host_write(2'd2, 16'h0001);
    chk("R11 rd_cmd high during read", 64'(rd_cmd), 64'd1);
    wait_idle();
    chk("R5 R7 read header bits", {got_bits[63:18], 18'h0},
        {exp_frame(1'b1, pa, ra, 16'h0) & 64'hFFFF_FFFF_FFFC_0000});
    chk("R7 oe pattern", got_oe, 64'hFFFF_FFFF_FFFC_0000);
    chk("R8 read data", 64'(rd_data), 64'(pat));
    chk("R11 rd_cmd self-clears", 64'(rd_cmd), 64'd0);
    chk("R2 busy length", 64'(busy_cyc), 64'(64 * n));
  endtask

  task automatic t_busy_ignore();
    logic [15:0] prev;
    prev = rd_data;
    host_write(2'd3, 16'h0003);
    host_write(2'd0, {6'h0, 5'h0F, 5'h10});
    clear_mon();
    host_write(2'd1, 16'h0001);
    repeat (200) @(negedge clk);
    host_write(2'd2, 16'h0001);
    host_write(2'd1, 16'hBEEF);
    wait_idle();
    chk("R10 single frame", 64'(rcnt), 64'd64);
    chk("R10 frame data unchanged", got_bits, exp_frame(1'b0, 5'h0F, 5'h10, 16'h0001));
    chk("R10 rd_data kept", 64'(rd_data), 64'(prev));
    chk("R10 rd_cmd not set", 64'(rd_cmd), 64'd0);
    chk("R2 busy length code 11", 64'(busy_cyc), 64'(64 * 28));
  endtask

  initial begin
    #750000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_code_zero();
    t_write(2'b01, 14, 5'h13, 5'h0A, 16'hA5C3);
    t_read(2'b10, 20, 5'h01, 5'h1F, 16'h3C96);
    t_busy_ignore();
    t_read(2'b01, 14, 5'h1E, 5'h01, 16'h8001);
    t_write(2'b11, 28, 5'h00, 5'h1F, 16'h7FFE);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule